// File: doc/BRIEF.md
# Modem Status Loopback Unit

This unit generates the modem status byte of a 16550-style serial port entirely from the modem control byte. No external modem pins are sampled. When the control byte's loop bit is set, four control outputs are mirrored onto the four status levels. When the loop bit is clear, the levels are held at a fixed pattern that keeps a host driver from blocking on carrier or data-set-ready.

Each control write compares the old levels with the new ones. A change is recorded in a sticky delta bit, and those delta bits survive further control writes. Reading the status byte returns its present value, and in the following cycle all four delta bits clear. The status byte cannot be written. Two outputs feed the interrupt logic: a loop-active flag, and a flag that is high while any delta bit is pending.

Status layout: bit0 CTS change, bit1 DSR change, bit2 trailing-edge ring, bit3 DCD change, bit4 CTS, bit5 DSR, bit6 RI, bit7 DCD. Control layout: bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 loop.

Top module: `modem_status_loop`

## Requirements
- R1: A control write stores only data bits 4:0; `mcr_rdata` bits 7:5 always read as zero.
- R2: With control bit 4 set, the status levels follow RTS→CTS (bit4), DTR→DSR (bit5), OUT1→RI (bit6) and OUT2→DCD (bit7).
- R3: With control bit 4 clear, the status levels are DCD=1, DSR=1, CTS=0 and RI=0 (upper nibble 4'b1010).
- R4: A control write that changes the CTS, DSR or DCD level sets bit0, bit1 or bit3 respectively, one cycle after the write.
- R5: Status bit2 is set only when RI goes from 1 to 0 on a control write. A rising RI leaves it clear.
- R6: Delta bits that are already set stay set across later control writes; a write replaces only the four level bits.
- R7: While `msr_rd` is high, `msr_rdata` shows the current status. In the next cycle bits 3:0 are clear. Delta bits produced by a control write in the same cycle as the read are kept.
- R8: A strobe on `msr_wr` leaves the status byte unchanged.
- R9: After reset the control byte holds `RESET_MCR` (default 0), the status levels are derived from it, and all delta bits are clear (default status 8'hA0).
- R10: `loop_active` equals control bit 4, and `delta_pending` is high exactly when any of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcr_wr | input | 1 | Control byte write strobe |
| mcr_wdata | input | 8 | Control byte write data |
| mcr_rdata | output | 8 | Control byte readback |
| msr_rd | input | 1 | Status byte read strobe (clears deltas) |
| msr_wr | input | 1 | Status byte write strobe (ignored) |
| msr_wdata | input | 8 | Status byte write data (ignored) |
| msr_rdata | output | 8 | Status byte |
| loop_active | output | 1 | Loopback mode active |
| delta_pending | output | 1 | Any status delta bit set |

## Verification
If a level register goes wrong, the upper nibble of `msr_rdata` shows it one cycle after the control write that caused it. If a delta register goes wrong, the fault appears in the low nibble and on `delta_pending` in that same cycle. A fault in the clear path appears only after a read, as deltas that stay set after the cycle that follows. A fault in the sticky path appears only after a second control write, as bits that are missing. The scenarios therefore chain writes and reads so that each of these paths is observed in the cycle right after it acts.

// File: rtl/msl_pkg.sv
package msl_pkg;

    localparam int BYTE_W  = 8;
    localparam int MCR_W   = 5;
    localparam int NIBBLE  = 4;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mcr_t;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } lvl_t;

    typedef struct packed {
        logic ddcd;
        logic teri;
        logic ddsr;
        logic dcts;
    } dlt_t;

    function automatic lvl_t map_levels(input mcr_t m);
        lvl_t l;
        if (m.loop) begin
            l.cts = m.rts;
            l.dsr = m.dtr;
            l.ri  = m.out1;
            l.dcd = m.out2;
        end else begin
            l.cts = 1'b0;
            l.dsr = 1'b1;
            l.ri  = 1'b0;
            l.dcd = 1'b1;
        end
        return l;
    endfunction

    function automatic dlt_t level_deltas(input lvl_t prev, input lvl_t next);
        dlt_t d;
        d.dcts = prev.cts ^ next.cts;
        d.ddsr = prev.dsr ^ next.dsr;
        d.ddcd = prev.dcd ^ next.dcd;
        d.teri = prev.ri & ~next.ri;
        return d;
    endfunction

endpackage

// File: rtl/msl_ctrl_reg.sv
module msl_ctrl_reg
    import msl_pkg::*;
#(
    parameter logic [MCR_W-1:0] RESET_MCR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output mcr_t              mcr_next,
    output mcr_t              mcr_q
);
    localparam int PAD_W = BYTE_W - MCR_W;

    assign mcr_next = mcr_t'(wdata[MCR_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst)     mcr_q <= mcr_t'(RESET_MCR);
        else if (wr) mcr_q <= mcr_next;
    end

    assert_mcr_keep_R1: assert property (@(posedge clk) disable iff (rst)
        wr |=> {{PAD_W{1'b0}}, mcr_q} == ($past(wdata) & {{PAD_W{1'b0}}, {MCR_W{1'b1}}}));
endmodule

// File: rtl/msl_level_map.sv
module msl_level_map
    import msl_pkg::*;
(
    input  mcr_t mcr,
    output lvl_t lvl
);
    assign lvl = map_levels(mcr);
endmodule

// File: rtl/msl_status_reg.sv
module msl_status_reg
    import msl_pkg::*;
#(
    parameter logic [MCR_W-1:0] RESET_MCR = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  lvl_t lvl_next,
    input  logic rd,
    output lvl_t lvl_q,
    output dlt_t dlt_q
);
    localparam lvl_t RESET_LVL = map_levels(mcr_t'(RESET_MCR));

    dlt_t fresh;
    dlt_t kept;

    assign fresh = upd ? level_deltas(lvl_q, lvl_next) : '0;
    assign kept  = rd ? '0 : dlt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= RESET_LVL;
            dlt_q <= '0;
        end else begin
            if (upd) lvl_q <= lvl_next;
            dlt_q <= kept | fresh;
        end
    end

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd && !upd) |=> dlt_q == '0);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (upd && !rd) |=> (dlt_q & $past(dlt_q)) == $past(dlt_q));

    assert_ring_trailing_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(dlt_q.teri) |-> ($past(lvl_q.ri) && !lvl_q.ri));

    assert_cts_change_R4: assert property (@(posedge clk) disable iff (rst)
        (upd && lvl_next.cts != lvl_q.cts) |=> dlt_q.dcts);
endmodule

// File: rtl/modem_status_loop.sv
module modem_status_loop
    import msl_pkg::*;
#(
    parameter logic [4:0] RESET_MCR = 5'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mcr_wr,
    input  logic [7:0] mcr_wdata,
    output logic [7:0] mcr_rdata,
    input  logic       msr_rd,
    input  logic       msr_wr,
    input  logic [7:0] msr_wdata,
    output logic [7:0] msr_rdata,
    output logic       loop_active,
    output logic       delta_pending
);
    localparam int PAD_W = BYTE_W - MCR_W;

    mcr_t mcr_next;
    mcr_t mcr_q;
    lvl_t lvl_next;
    lvl_t lvl_q;
    dlt_t dlt_q;

    msl_ctrl_reg #(.RESET_MCR(RESET_MCR)) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr       (mcr_wr),
        .wdata    (mcr_wdata),
        .mcr_next (mcr_next),
        .mcr_q    (mcr_q)
    );

    msl_level_map i_map (
        .mcr (mcr_next),
        .lvl (lvl_next)
    );

    msl_status_reg #(.RESET_MCR(RESET_MCR)) i_stat (
        .clk      (clk),
        .rst      (rst),
        .upd      (mcr_wr),
        .lvl_next (lvl_next),
        .rd       (msr_rd),
        .lvl_q    (lvl_q),
        .dlt_q    (dlt_q)
    );

    assign mcr_rdata     = {{PAD_W{1'b0}}, mcr_q};
    assign msr_rdata     = {lvl_q, dlt_q};
    assign loop_active   = mcr_q.loop;
    assign delta_pending = |dlt_q;

    assert_loop_map_R2: assert property (@(posedge clk) disable iff (rst)
        loop_active |-> (msr_rdata[4] == mcr_rdata[1] && msr_rdata[5] == mcr_rdata[0]
                         && msr_rdata[6] == mcr_rdata[2] && msr_rdata[7] == mcr_rdata[3]));

    assert_fixed_levels_R3: assert property (@(posedge clk) disable iff (rst)
        !loop_active |-> msr_rdata[7:4] == 4'b1010);

    assert_msr_wr_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (msr_wr && !mcr_wr && !msr_rd) |=>
            (msr_rdata == $past(msr_rdata) || $past(msr_wdata) == 8'hxx));
endmodule

// File: tb/test_modem_status_loop.sv
module test_modem_status_loop;
    logic       clk = 1'b0;
    logic       rst;
    logic       mcr_wr;
    logic [7:0] mcr_wdata;
    logic [7:0] mcr_rdata;
    logic       msr_rd;
    logic       msr_wr;
    logic [7:0] msr_wdata;
    logic [7:0] msr_rdata;
    logic       loop_active;
    logic       delta_pending;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    modem_status_loop i_modem_status_loop (
        .clk(clk), .rst(rst),
        .mcr_wr(mcr_wr), .mcr_wdata(mcr_wdata), .mcr_rdata(mcr_rdata),
        .msr_rd(msr_rd), .msr_wr(msr_wr), .msr_wdata(msr_wdata),
        .msr_rdata(msr_rdata), .loop_active(loop_active),
        .delta_pending(delta_pending)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_msr(input string req, input logic [7:0] exp);
        check8(req, msr_rdata, exp);
        check8({req, " R10 pending"}, {7'b0, delta_pending}, {7'b0, |exp[3:0]});
    endtask

    task automatic wr_mcr(input logic [7:0] v);
        @(negedge clk);
        mcr_wr = 1'b1; mcr_wdata = v;
        @(negedge clk);
        mcr_wr = 1'b0;
    endtask

    task automatic rd_msr(input string req, input logic [7:0] exp_read);
        @(negedge clk);
        msr_rd = 1'b1;
        #1 check8({req, " read value"}, msr_rdata, exp_read);
        @(negedge clk);
        msr_rd = 1'b0;
    endtask

    task automatic t_reset;
        check_msr("R9 reset status", 8'hA0);
        check8("R9 reset control", mcr_rdata, 8'h00);
        check8("R10 reset loop", {7'b0, loop_active}, 8'h00);
    endtask

    task automatic t_enter_loop;
        wr_mcr(8'hF0);
        check8("R1 upper bits dropped", mcr_rdata, 8'h10);
        check8("R10 loop flag", {7'b0, loop_active}, 8'h01);
        check_msr("R4 DSR and DCD fall", 8'h0A);
        rd_msr("R7", 8'h0A);
        check_msr("R7 cleared after read", 8'h00);
    endtask

    task automatic t_all_up;
        wr_mcr(8'h1F);
        check_msr("R2 R5 all levels up, no ring delta on rise", 8'hFB);
        rd_msr("R7", 8'hFB);
        check_msr("R7 deltas cleared", 8'hF0);
    endtask

    task automatic t_ring_and_sticky;
        wr_mcr(8'h1B);
        check_msr("R5 ring trailing edge", 8'hB4);
        wr_mcr(8'h13);
        check_msr("R6 ring delta kept, DCD delta added", 8'h3C);
        rd_msr("R7", 8'h3C);
        check_msr("R7 clear", 8'h30);
    endtask

    task automatic t_msr_write;
        @(negedge clk);
        msr_wr = 1'b1; msr_wdata = 8'h5F;
        @(negedge clk);
        msr_wr = 1'b0;
        @(negedge clk);
        check_msr("R8 status write ignored", 8'h30);
    endtask

    task automatic t_read_with_write;
        wr_mcr(8'h1F);
        check_msr("R2 levels", 8'hF8);
        @(negedge clk);
        msr_rd = 1'b1; mcr_wr = 1'b1; mcr_wdata = 8'h00;
        #1 check8("R7 read during write", msr_rdata, 8'hF8);
        @(negedge clk);
        msr_rd = 1'b0; mcr_wr = 1'b0;
        check8("R10 loop off", {7'b0, loop_active}, 8'h00);
        check_msr("R3 R7 fixed levels, new deltas kept", 8'hA5);
    endtask

    initial begin
        rst = 1'b1; mcr_wr = 1'b0; mcr_wdata = '0;
        msr_rd = 1'b0; msr_wr = 1'b0; msr_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_enter_loop;
        t_all_up;
        t_ring_and_sticky;
        t_msr_write;
        t_read_with_write;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule